// File: doc/BRIEF.md
# Paged Byte Register Space with Request Mailboxes

This block is the target side of a byte-wide register bus. The bus offers a 7-bit offset, write data, a write strobe, a read strobe and registered read data. The address space has 16 pages of 128 bytes. A page-select register at the top offset of every page picks which page the other offsets reach.

The lower ten pages are plain storage, and page 0 also carries read-only identification fields. Each of the upper six pages is a mailbox. Software puts an entry number in the index register and starts a transfer by writing a request code to the semaphore. It then polls the semaphore until it reads zero. A read request loads the selected entry of that mailbox's private backing array into the latch registers. A write request stores the latch registers into that entry. The backing array stands in for the firmware that would normally service these requests.

Top module: `mbox_regspace`

## Requirements
- R1: After reset the page select is 0, and every writable direct byte, mailbox index, semaphore and latch reads 0.
- R2: Offset 0x7F on every page is the page select. A write loads wdata[3:0], and a read returns {4'b0, page}. No other access changes the page.
- R3: On pages 0 to 9, each offset 0x00 to 0x7E is an independent read/write byte, except the identification bytes of R4.
- R4: Page 0 holds four read-only fields, each stored most significant byte first: ID_VAL at 0x01-0x02, REV_VAL at 0x03-0x04, FW_VAL at 0x05-0x06 and CFG_VAL at 0x07-0x0A. Writes to these offsets have no effect.
- R5: Each mailbox page has the index at 0x00 (low 3 bits kept, upper bits read 0), the semaphore at 0x01 and LATCH_N=4 latch bytes at 0x02-0x05. All other offsets read 0 and ignore writes.
- R6: A semaphore write with bit 0 set is a read request. When it completes, the latches hold the backing entry chosen by the index.
- R7: A semaphore write with bit 1 set and bit 0 clear is a write request. When it completes, the chosen backing entry holds the latch bytes.
- R8: After a request the semaphore reads back its request bit (0x01 for read, 0x02 for write) for exactly SVC_LAT consecutive polls. It then self-clears to 0. A semaphore write of 0 starts nothing.
- R9: While a request is pending, writes to the latches, index and semaphore are ignored, and latch reads return the contents from before the request.
- R10: Read data is registered: it takes the addressed value on the clock edge where the read strobe is high, and holds otherwise.
- R11: Each mailbox has its own backing array. Requests on one mailbox never alter another mailbox's entries.
- R12: A semaphore write with both bits set is treated as a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte offset within the selected page |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
Every byte of the ten direct pages is written with an address-derived pattern and read back, so aliasing between pages or offsets shows up as a wrong value, and the identification bytes show whether they are protected. All entries of all six mailboxes are written through write requests before any of them is read back through read requests, which separates private backing arrays from a shared one. Timed accesses during a pending request show whether latch, index and semaphore writes are blocked, and counting polls pins the service latency exactly. Requests with both bits set and with zero, and accesses to undefined mailbox offsets, cover the decode corners.

// File: rtl/mbox_regspace_pkg.sv
package mbox_regspace_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'b00,
    XF_READ  = 2'b01,
    XF_WRITE = 2'b10
  } xfer_e;

  // Request decode: bit 0 (read) wins over bit 1 (write).
  function automatic xfer_e sem_decode(logic [7:0] wd);
    if (wd[0])      return XF_READ;
    else if (wd[1]) return XF_WRITE;
    else            return XF_IDLE;
  endfunction

  function automatic logic is_id_off(int off);
    return (off >= 1) && (off <= 10);
  endfunction

  // Identification bytes, most significant byte at the lower offset.
  function automatic logic [7:0] id_byte(int off, logic [15:0] idv, logic [15:0] revv,
                                         logic [15:0] fwv, logic [31:0] cfgv);
    case (off)
      1:       return idv[15:8];
      2:       return idv[7:0];
      3:       return revv[15:8];
      4:       return revv[7:0];
      5:       return fwv[15:8];
      6:       return fwv[7:0];
      7:       return cfgv[31:24];
      8:       return cfgv[23:16];
      9:       return cfgv[15:8];
      10:      return cfgv[7:0];
      default: return 8'h00;
    endcase
  endfunction

  // Flat index of a direct byte; the selector offset is not stored.
  function automatic int dir_index(int page, int off, int regs);
    return page * (regs - 1) + off;
  endfunction

endpackage

// File: rtl/mbox_direct_bank.sv
module mbox_direct_bank
  import mbox_regspace_pkg::*;
#(
  parameter int          DIRECT_PAGES = 10,
  parameter int          REGS         = 128,
  parameter int          PG_W         = 4,
  parameter logic [15:0] ID_VAL       = 16'h0000,
  parameter logic [15:0] REV_VAL      = 16'h0000,
  parameter logic [15:0] FW_VAL       = 16'h0000,
  parameter logic [31:0] CFG_VAL      = 32'h0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PG_W-1:0]         page,
  input  logic [$clog2(REGS)-1:0] off,
  input  logic                    we,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata
);
  localparam int DEPTH = DIRECT_PAGES * (REGS - 1);
  localparam int AW    = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx;
  logic          in_range;
  logic          id_hit;

  assign idx      = AW'(dir_index(int'(page), int'(off), REGS));
  assign in_range = (int'(page) < DIRECT_PAGES) && (int'(off) < REGS - 1);
  assign id_hit   = (page == '0) && is_id_off(int'(off));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we && in_range && !id_hit) begin
      mem[idx] <= wdata;
    end
  end

  always_comb begin
    if (id_hit)        rdata = id_byte(int'(off), ID_VAL, REV_VAL, FW_VAL, CFG_VAL);
    else if (in_range) rdata = mem[idx];
    else               rdata = 8'h00;
  end
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel
  import mbox_regspace_pkg::*;
#(
  parameter int REGS    = 128,
  parameter int LATCH_N = 4,
  parameter int ENTRIES = 8,
  parameter int SVC_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel,
  input  logic [$clog2(REGS)-1:0] off,
  input  logic                    we,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    busy,
  output logic                    start,
  output logic                    done
);
  localparam int OFF_W    = $clog2(REGS);
  localparam int IX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OFF_MASK = 0;
  localparam int OFF_SEM  = 1;
  localparam int OFF_LAT0 = 2;

  xfer_e           pend_q;
  logic [3:0]      cnt_q;
  logic [IX_W-1:0] mask_q;
  logic [7:0]      latch_q [LATCH_N];
  logic [7:0]      store_q [ENTRIES][LATCH_N];
  logic            wr_hit;
  xfer_e           req;

  assign wr_hit = sel && we;
  assign req    = sem_decode(wdata);
  assign busy   = (pend_q != XF_IDLE);
  assign start  = wr_hit && (off == OFF_W'(OFF_SEM)) && !busy && (req != XF_IDLE);
  assign done   = busy && (cnt_q == 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= XF_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
      for (int b = 0; b < LATCH_N; b++) latch_q[b] <= 8'h00;
      for (int e = 0; e < ENTRIES; e++)
        for (int b = 0; b < LATCH_N; b++) store_q[e][b] <= 8'h00;
    end else begin
      if (start) begin
        pend_q <= req;
        cnt_q  <= 4'(SVC_LAT);
      end else if (done) begin
        pend_q <= XF_IDLE;
        cnt_q  <= '0;
      end else if (busy) begin
        cnt_q <= cnt_q - 4'd1;
      end

      if (wr_hit && !busy && off == OFF_W'(OFF_MASK)) mask_q <= wdata[IX_W-1:0];

      for (int b = 0; b < LATCH_N; b++) begin
        if (done && pend_q == XF_READ)
          latch_q[b] <= store_q[mask_q][b];
        else if (wr_hit && !busy && off == OFF_W'(OFF_LAT0 + b))
          latch_q[b] <= wdata;
      end

      if (done && pend_q == XF_WRITE)
        for (int b = 0; b < LATCH_N; b++) store_q[mask_q][b] <= latch_q[b];
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (off == OFF_W'(OFF_MASK)) rdata = 8'(mask_q);
    if (off == OFF_W'(OFF_SEM))  rdata = {6'b0, pend_q};
    for (int b = 0; b < LATCH_N; b++)
      if (off == OFF_W'(OFF_LAT0 + b)) rdata = latch_q[b];
  end
endmodule

// File: rtl/mbox_regspace.sv
module mbox_regspace
  import mbox_regspace_pkg::*;
#(
  parameter int          NUM_PAGES    = 16,
  parameter int          REGS         = 128,
  parameter int          DIRECT_PAGES = 10,
  parameter int          LATCH_N      = 4,
  parameter int          ENTRIES      = 8,
  parameter int          SVC_LAT      = 3,
  parameter logic [15:0] ID_VAL       = 16'h3A71,
  parameter logic [15:0] REV_VAL      = 16'h0102,
  parameter logic [15:0] FW_VAL       = 16'h0815,
  parameter logic [31:0] CFG_VAL      = 32'h20240A0B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(REGS)-1:0] bus_addr,
  input  logic [7:0]              bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [7:0]              bus_rdata
);
  localparam int OFF_W = $clog2(REGS);
  localparam int PG_W  = $clog2(NUM_PAGES);
  localparam int NMB   = NUM_PAGES - DIRECT_PAGES;

  logic [PG_W-1:0] page_q;
  logic            sel_hit;
  logic            is_direct;
  logic [PG_W-1:0] mb_idx;
  logic [7:0]      dir_rdata;
  logic [7:0]      mb_rdata [NMB];
  logic [NMB-1:0]  mb_busy;
  logic [NMB-1:0]  mb_start;
  logic [NMB-1:0]  mb_done;
  logic [7:0]      rd_mux;

  assign sel_hit   = (bus_addr == OFF_W'(REGS - 1));
  assign is_direct = (page_q < PG_W'(DIRECT_PAGES));
  assign mb_idx    = page_q - PG_W'(DIRECT_PAGES);

  always_ff @(posedge clk) begin
    if (!rst_n)                  page_q <= '0;
    else if (bus_wr && sel_hit)  page_q <= bus_wdata[PG_W-1:0];
  end

  mbox_direct_bank #(
    .DIRECT_PAGES(DIRECT_PAGES), .REGS(REGS), .PG_W(PG_W),
    .ID_VAL(ID_VAL), .REV_VAL(REV_VAL), .FW_VAL(FW_VAL), .CFG_VAL(CFG_VAL)
  ) u_direct (
    .clk   (clk),
    .rst_n (rst_n),
    .page  (page_q),
    .off   (bus_addr),
    .we    (bus_wr && !sel_hit && is_direct),
    .wdata (bus_wdata),
    .rdata (dir_rdata)
  );

  for (genvar m = 0; m < NMB; m++) begin : g_mb
    mbox_channel #(
      .REGS(REGS), .LATCH_N(LATCH_N), .ENTRIES(ENTRIES), .SVC_LAT(SVC_LAT)
    ) u_mb (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (!is_direct && !sel_hit && (mb_idx == PG_W'(m))),
      .off   (bus_addr),
      .we    (bus_wr),
      .wdata (bus_wdata),
      .rdata (mb_rdata[m]),
      .busy  (mb_busy[m]),
      .start (mb_start[m]),
      .done  (mb_done[m])
    );
  end

  always_comb begin
    rd_mux = 8'h00;
    if (sel_hit)        rd_mux = 8'(page_q);
    else if (is_direct) rd_mux = dir_rdata;
    else
      for (int m = 0; m < NMB; m++)
        if (mb_idx == PG_W'(m)) rd_mux = mb_rdata[m];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mbox_regspace_chk.sv
module mbox_regspace_chk #(
  parameter int OFF_W   = 7,
  parameter int PG_W    = 4,
  parameter int NMB     = 6,
  parameter int SVC_LAT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFF_W-1:0] bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_rdata,
  input logic [PG_W-1:0]  page_q,
  input logic [NMB-1:0]   mb_busy,
  input logic [NMB-1:0]   mb_start,
  input logic [NMB-1:0]   mb_done
);
  a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == {OFF_W{1'b1}}) |=> $stable(page_q));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  a_r11_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mb_start));

  for (genvar i = 0; i < NMB; i++) begin : g_chk
    logic [4:0] age_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        age_q <= '0;
      else if (mb_start[i])              age_q <= 5'd1;
      else if (mb_busy[i] && !mb_done[i]) age_q <= age_q + 5'd1;
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      mb_done[i] |-> age_q == 5'(SVC_LAT));

    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      mb_start[i] |=> mb_busy[i]);

    a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mb_done[i] |=> !mb_busy[i]);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      mb_busy[i] && !mb_done[i] |=> mb_busy[i]);
  end
endmodule

bind mbox_regspace mbox_regspace_chk #(
  .OFF_W($clog2(REGS)), .PG_W($clog2(NUM_PAGES)),
  .NMB(NUM_PAGES - DIRECT_PAGES), .SVC_LAT(SVC_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .page_q    (page_q),
  .mb_busy   (mb_busy),
  .mb_start  (mb_start),
  .mb_done   (mb_done)
);

// File: tb/mbox_regspace_tb.sv
`timescale 1ns/1ps
module mbox_regspace_tb;
  localparam int          DIRECT = 10;
  localparam int          NMB    = 6;
  localparam int          LAT    = 3;
  localparam logic [15:0] IDV    = 16'h3A71;
  localparam logic [15:0] REVV   = 16'h0102;
  localparam logic [15:0] FWV    = 16'h0815;
  localparam logic [31:0] CFGV   = 32'h20240A0B;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] addr;
  logic [7:0] wdata;
  logic       wr, rd;
  logic [7:0] rdata;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  mbox_regspace #(
    .SVC_LAT(LAT), .ID_VAL(IDV), .REV_VAL(REVV), .FW_VAL(FWV), .CFG_VAL(CFGV)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata)
  );

  function automatic logic [7:0] dpat(int p, int o);
    return 8'((p * 37 + o * 11 + 5) & 255);
  endfunction

  function automatic logic [7:0] mpat(int m, int e, int b);
    return 8'((m * 53 + e * 19 + b * 7 + 129) & 255);
  endfunction

  function automatic logic [7:0] id_exp(int o);
    logic [79:0] all;
    all = {IDV, REVV, FWV, CFGV};
    return all[79 - (o - 1) * 8 -: 8];
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_b(int a, logic [7:0] d);
    addr = 7'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_b(int a, output logic [7:0] d);
    addr = 7'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic poll(output int busy_reads);
    logic [7:0] v;
    busy_reads = 0;
    for (int k = 0; k < 40; k++) begin
      rd_b(1, v);
      if (v == 8'h00) break;
      busy_reads++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R4 identification
    rd_b(8'h7F, v); check("R1 page", v, 8'h00);
    rd_b(0, v);     check("R1 direct", v, 8'h00);
    for (int o = 1; o <= 10; o++) begin
      rd_b(o, v); check("R4 id reset", v, id_exp(o));
    end
    wr_b(8'h7F, 8'd10);
    for (int o = 0; o < 6; o++) begin
      rd_b(o, v); check("R1 mailbox", v, 8'h00);
    end

    // R3 direct sweep, R4 writes to identification ignored
    for (int p = 0; p < DIRECT; p++) begin
      wr_b(8'h7F, 8'(p));
      for (int o = 0; o < 127; o++) wr_b(o, dpat(p, o));
    end
    for (int p = 0; p < DIRECT; p++) begin
      wr_b(8'h7F, 8'(p));
      for (int o = 0; o < 127; o++) begin
        rd_b(o, v);
        if (p == 0 && o >= 1 && o <= 10) check("R4 id readonly", v, id_exp(o));
        else                              check("R3 direct", v, dpat(p, o));
      end
    end

    // R7 write requests into every entry of every mailbox, R8 latency
    for (int m = 0; m < NMB; m++) begin
      wr_b(8'h7F, 8'(DIRECT + m));
      for (int e = 0; e < 8; e++) begin
        for (int b = 0; b < 4; b++) wr_b(2 + b, mpat(m, e, b));
        wr_b(0, 8'(e));
        wr_b(1, 8'h02);
        poll(cnt);
        check("R8 write latency", 8'(cnt), 8'(LAT));
      end
    end
    // R6 read back after all writes, R11 independent arrays
    for (int m = 0; m < NMB; m++) begin
      wr_b(8'h7F, 8'(DIRECT + m));
      for (int b = 0; b < 4; b++) wr_b(2 + b, 8'h00);
      for (int e = 0; e < 8; e++) begin
        wr_b(0, 8'(e));
        wr_b(1, 8'h01);
        poll(cnt);
        check("R8 read latency", 8'(cnt), 8'(LAT));
        for (int b = 0; b < 4; b++) begin
          rd_b(2 + b, v); check("R6 R11 latch", v, mpat(m, e, b));
        end
      end
    end

    // R9 writes during a pending request are ignored
    wr_b(8'h7F, 8'd12);
    for (int b = 0; b < 4; b++) wr_b(2 + b, 8'(8'h11 + b));
    wr_b(0, 8'd6);
    wr_b(1, 8'h02);
    wr_b(2, 8'hAA);
    wr_b(0, 8'd1);
    rd_b(2, v); check("R9 latch during busy", v, 8'h11);
    poll(cnt);
    rd_b(0, v); check("R9 index kept", v, 8'd6);
    rd_b(2, v); check("R9 latch kept", v, 8'h11);
    for (int b = 0; b < 4; b++) wr_b(2 + b, 8'h00);
    wr_b(1, 8'h01);
    wr_b(1, 8'h02);
    rd_b(1, v); check("R9 sem ignored", v, 8'h01);
    poll(cnt);
    for (int b = 0; b < 4; b++) begin
      rd_b(2 + b, v); check("R9 stored entry", v, 8'(8'h11 + b));
    end

    // R12 both request bits act as a read
    wr_b(8'h7F, 8'd13);
    for (int b = 0; b < 4; b++) wr_b(2 + b, 8'h00);
    wr_b(0, 8'd2);
    wr_b(1, 8'h03);
    rd_b(1, v); check("R12 sem value", v, 8'h01);
    poll(cnt);
    for (int b = 0; b < 4; b++) begin
      rd_b(2 + b, v); check("R12 latch", v, mpat(3, 2, b));
    end

    // R8 zero request starts nothing; R5 undefined offsets and index width
    wr_b(1, 8'h00);
    rd_b(1, v); check("R8 zero sem", v, 8'h00);
    rd_b(2, v); check("R8 zero no xfer", v, mpat(3, 2, 0));
    wr_b(8'h40, 8'h5A);
    rd_b(8'h40, v); check("R5 undefined", v, 8'h00);
    rd_b(6, v);     check("R5 past latches", v, 8'h00);
    wr_b(0, 8'hFF);
    rd_b(0, v);     check("R5 index width", v, 8'h07);

    // R2 page select from a mailbox page, upper bits dropped
    wr_b(8'h7F, 8'hF4);
    rd_b(8'h7F, v); check("R2 page readback", v, 8'h04);
    rd_b(0, v);     check("R2 page routes", v, dpat(4, 0));

    // R10 read data holds without a read strobe
    rd_b(8'h7F, v);
    addr = 7'd0;
    @(negedge clk);
    check("R10 hold", rdata, 8'h04);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule